// File: doc/BRIEF.md
# Masked Interrupt and Sync-Event Unit

This block folds five interrupt sources into one level-high interrupt line. Three sources follow FIFO fill levels that arrive as inputs. The command and transmit levels raise a source while they sit below a low watermark. The receive level raises a source while it sits above a high watermark. All three drop again without help once the level crosses back. The other two sources are sticky event flags. One is set by an 8-bit event ID accepted on a ready/valid stream, and that ID is also latched for software to read. The other is set by a single offload-event strobe.

Software reaches the block through a simple register port with separate write and read channels; read data is registered and appears one cycle after the read request. The port holds a mask register, a raw-source view, a masked pending view whose write-1-to-clear action drops the sticky flags, and the last event ID. Each sticky flag is a two-state machine, `EV_IDLE` and `EV_FLAGGED`. An accepted event takes it from `EV_IDLE` to `EV_FLAGGED`. A clear with no event in the same cycle takes it back from `EV_FLAGGED` to `EV_IDLE`. Both states otherwise hold.

Top module: `irq_sync_unit`

## Requirements
- R1: After reset the mask register reads 0, the raw and pending registers read 0 when every level sits between its watermarks, the event-ID register reads 0, and `irq` is low.
- R2: Byte offset 0x80 is the mask register. Bits 4:0 take the written value and bits 31:5 read 0. A mask bit of 0 blocks the source at the same bit position, and the register changes only when 0x80 is written.
- R3: Raw bit 0 (command low) is 1 exactly while `cmd_level` is below `CMD_LOW_MARK` (default 4).
- R4: Raw bit 1 (transmit low) is 1 exactly while `tx_level` is below `TX_LOW_MARK` (default 4).
- R5: Raw bit 2 (receive high) is 1 exactly while `rx_level` is above `RX_HIGH_MARK` (default 2**RX_AW-4 = 28).
- R6: `sync_ready` is always 1. An event with `sync_valid` high is accepted in that cycle. From the next cycle, its ID reads back in bits 7:0 of offset 0xC0 and raw bit 3 is 1.
- R7: Raw bit 3 stays 1 until a write to offset 0x84 has bit 3 set. If an event arrives in the same cycle as that write, the bit stays 1.
- R8: A cycle with `offload_sync_valid` high sets raw bit 4 from the next cycle. The bit is cleared by writing 0x84 with bit 4 set, and a strobe in the same cycle as the clear wins.
- R9: Offset 0x88 reads the raw sources and offset 0x84 reads the raw sources ANDed with the mask. Bits 31:5 of both read 0.
- R10: `irq` is 1 exactly when at least one pending bit is 1.
- R11: Writing 1 to bits 2:0 of offset 0x84 has no effect, because those bits keep following the levels.
- R12: A read of any offset not listed returns 0. Writes to 0x88, 0xC0 or any unlisted offset change nothing that can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| cmd_level | input | CMD_AW+1 | Command FIFO fill level |
| tx_level | input | TX_AW+1 | Transmit FIFO fill level |
| rx_level | input | RX_AW+1 | Receive FIFO fill level |
| sync_valid | input | 1 | Event ID valid |
| sync_id | input | 8 | Event ID |
| sync_ready | output | 1 | Event accept, always 1 |
| offload_sync_valid | input | 1 | Offload event strobe |
| irq | output | 1 | Combined level-high interrupt |

## Verification
The assertions take for granted that every input is a known value at each rising edge once reset is released. They also assume that a write and an event may coincide in any combination, so the set-wins rule is always in play. The bench drives every input at the falling edge and holds it for one full cycle. The random levels stay within each FIFO's legal range of 0 to depth, and random offsets come only from the mapped set plus two unmapped ones, so each read has a defined expected value.

// File: rtl/irq_sync_pkg.sv
`timescale 1ns/1ps
package irq_sync_pkg;
    localparam int NSRC = 5;

    localparam int SRC_CMD_LOW  = 0;
    localparam int SRC_TX_LOW   = 1;
    localparam int SRC_RX_HIGH  = 2;
    localparam int SRC_SYNC     = 3;
    localparam int SRC_OFFLOAD  = 4;

    localparam logic [11:0] OFS_MASK    = 12'h080;
    localparam logic [11:0] OFS_PENDING = 12'h084;
    localparam logic [11:0] OFS_RAW     = 12'h088;
    localparam logic [11:0] OFS_SYNC_ID = 12'h0C0;

    typedef enum logic [0:0] {
        EV_IDLE    = 1'b0,
        EV_FLAGGED = 1'b1
    } ev_state_e;

    typedef enum logic [0:0] {
        MARK_BELOW = 1'b0,
        MARK_ABOVE = 1'b1
    } mark_kind_e;
endpackage

// File: rtl/irq_watermark.sv
`timescale 1ns/1ps
module irq_watermark
    import irq_sync_pkg::*;
#(
    parameter int         LVL_W = 5,
    parameter int         MARK  = 4,
    parameter mark_kind_e KIND  = MARK_BELOW
) (
    input  logic [LVL_W-1:0] level,
    output logic             hit
);
    localparam logic [LVL_W-1:0] MARK_V = LVL_W'(MARK);

    generate
        if (KIND == MARK_BELOW) begin : g_below
            assign hit = (level < MARK_V);
        end else begin : g_above
            assign hit = (level > MARK_V);
        end
    endgenerate
endmodule

// File: rtl/irq_sticky_flag.sv
`timescale 1ns/1ps
module irq_sticky_flag
    import irq_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    ev_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE:    if (set_i)           state_d = EV_FLAGGED;
            EV_FLAGGED: if (clr_i && !set_i) state_d = EV_IDLE;
            default:                         state_d = EV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            EV_FLAGGED: flag_o = 1'b1;
            default:    flag_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
module irq_regs
    import irq_sync_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int ID_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [NSRC-1:0]   src_i,
    input  logic              id_load_i,
    input  logic [ID_W-1:0]   id_i,
    output logic [NSRC-1:0]   mask_o,
    output logic [NSRC-1:0]   clr_o,
    output logic [ID_W-1:0]   id_o
);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PENDING);
    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(OFS_SYNC_ID);

    logic [NSRC-1:0] mask_q;
    logic [ID_W-1:0] id_q;
    logic [31:0]     rd_d;
    logic            unused_wr_hi;

    assign unused_wr_hi = ^wr_data[31:NSRC];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         mask_q <= '0;
        else if (wr_en && wr_addr == A_MASK) mask_q <= wr_data[NSRC-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         id_q <= '0;
        else if (id_load_i) id_q <= id_i;
    end

    assign clr_o = (wr_en && wr_addr == A_PEND) ? wr_data[NSRC-1:0] : '0;

    always_comb begin
        rd_d = '0;
        if (rd_addr == A_MASK)      rd_d[NSRC-1:0] = mask_q;
        else if (rd_addr == A_PEND) rd_d[NSRC-1:0] = src_i & mask_q;
        else if (rd_addr == A_RAW)  rd_d[NSRC-1:0] = src_i;
        else if (rd_addr == A_ID)   rd_d[ID_W-1:0] = id_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_d;
    end

    assign mask_o = mask_q;
    assign id_o   = id_q;
endmodule

// File: rtl/irq_sync_unit.sv
`timescale 1ns/1ps
module irq_sync_unit
    import irq_sync_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int CMD_AW       = 4,
    parameter int TX_AW        = 5,
    parameter int RX_AW        = 5,
    parameter int CMD_LOW_MARK = 4,
    parameter int TX_LOW_MARK  = 4,
    parameter int RX_HIGH_MARK = (1 << RX_AW) - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [CMD_AW:0]   cmd_level,
    input  logic [TX_AW:0]    tx_level,
    input  logic [RX_AW:0]    rx_level,
    input  logic              sync_valid,
    input  logic [7:0]        sync_id,
    output logic              sync_ready,
    input  logic              offload_sync_valid,
    output logic              irq
);
    localparam int ID_W    = 8;
    localparam int NSTICKY = 2;

    logic [NSRC-1:0]    src_raw;
    logic [NSRC-1:0]    mask_q;
    logic [NSRC-1:0]    clr_req;
    logic [ID_W-1:0]    sync_id_q;
    logic               sync_take;
    logic [NSTICKY-1:0] sticky_set;

    assign sync_ready = 1'b1;
    assign sync_take  = sync_valid && sync_ready;

    irq_watermark #(.LVL_W(CMD_AW+1), .MARK(CMD_LOW_MARK), .KIND(MARK_BELOW)) u_cmd_mark (
        .level (cmd_level),
        .hit   (src_raw[SRC_CMD_LOW])
    );

    irq_watermark #(.LVL_W(TX_AW+1), .MARK(TX_LOW_MARK), .KIND(MARK_BELOW)) u_tx_mark (
        .level (tx_level),
        .hit   (src_raw[SRC_TX_LOW])
    );

    irq_watermark #(.LVL_W(RX_AW+1), .MARK(RX_HIGH_MARK), .KIND(MARK_ABOVE)) u_rx_mark (
        .level (rx_level),
        .hit   (src_raw[SRC_RX_HIGH])
    );

    assign sticky_set = {offload_sync_valid, sync_take};

    generate
        for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
            irq_sticky_flag u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (sticky_set[i]),
                .clr_i  (clr_req[SRC_SYNC+i]),
                .flag_o (src_raw[SRC_SYNC+i])
            );
        end
    endgenerate

    irq_regs #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .src_i     (src_raw),
        .id_load_i (sync_take),
        .id_i      (sync_id),
        .mask_o    (mask_q),
        .clr_o     (clr_req),
        .id_o      (sync_id_q)
    );

    assign irq = |(src_raw & mask_q);
endmodule

// File: rtl/irq_sync_chk.sv
`timescale 1ns/1ps
module irq_sync_chk
    import irq_sync_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              sync_valid,
    input logic [7:0]        sync_id,
    input logic              offload_sync_valid,
    input logic              irq,
    input logic [NSRC-1:0]   src_raw,
    input logic [NSRC-1:0]   mask_q,
    input logic [7:0]        sync_id_q
);
    logic pend_wr, mask_wr;
    assign pend_wr = wr_en && (wr_addr == ADDR_W'(OFS_PENDING));
    assign mask_wr = wr_en && (wr_addr == ADDR_W'(OFS_MASK));

    AST_SYNC_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) sync_valid |=> src_raw[SRC_SYNC]); // R6
    AST_SYNC_ID_LATCH: assert property (@(posedge clk) disable iff (!rst_n) sync_valid |=> sync_id_q == $past(sync_id)); // R6
    AST_SYNC_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (src_raw[SRC_SYNC] && !(pend_wr && wr_data[SRC_SYNC])) |=> src_raw[SRC_SYNC]); // R7
    AST_SYNC_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (pend_wr && wr_data[SRC_SYNC] && !sync_valid) |=> !src_raw[SRC_SYNC]); // R7
    AST_OFFLOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n) offload_sync_valid |=> src_raw[SRC_OFFLOAD]); // R8
    AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !mask_wr |=> $stable(mask_q)); // R2
    AST_MASK_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n) (mask_q == '0) |-> !irq); // R10
    AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (src_raw != '0)); // R10
endmodule

bind irq_sync_unit irq_sync_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .wr_en              (wr_en),
    .wr_addr            (wr_addr),
    .wr_data            (wr_data),
    .sync_valid         (sync_valid),
    .sync_id            (sync_id),
    .offload_sync_valid (offload_sync_valid),
    .irq                (irq),
    .src_raw            (src_raw),
    .mask_q             (mask_q),
    .sync_id_q          (sync_id_q)
);

// File: tb/sim_irq_sync_unit.sv
`timescale 1ns/1ps
module sim_irq_sync_unit;
    localparam int AW = 10;
    localparam int CMD_W = 5;
    localparam int TX_W  = 6;
    localparam int RX_W  = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [31:0]     wr_data = '0;
    logic            rd_en = 1'b0;
    logic [AW-1:0]   rd_addr = '0;
    logic [31:0]     rd_data;
    logic [CMD_W-1:0] cmd_level = 5'd8;
    logic [TX_W-1:0]  tx_level  = 6'd8;
    logic [RX_W-1:0]  rx_level  = 6'd10;
    logic            sync_valid = 1'b0;
    logic [7:0]      sync_id = '0;
    logic            sync_ready;
    logic            offload_sync_valid = 1'b0;
    logic            irq;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    logic [4:0] m_mask = '0;
    bit         m_f3 = 1'b0;
    bit         m_f4 = 1'b0;
    logic [7:0] m_id = '0;

    always #2.5 clk = ~clk;

    irq_sync_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .cmd_level(cmd_level), .tx_level(tx_level), .rx_level(rx_level),
        .sync_valid(sync_valid), .sync_id(sync_id), .sync_ready(sync_ready),
        .offload_sync_valid(offload_sync_valid), .irq(irq)
    );

    function automatic logic [4:0] exp_src();
        logic [4:0] s;
        s[0] = (cmd_level < 4);
        s[1] = (tx_level < 4);
        s[2] = (rx_level > 28);
        s[3] = m_f3;
        s[4] = m_f4;
        return s;
    endfunction

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        case (a)
            10'h080: return {27'd0, m_mask};
            10'h084: return {27'd0, exp_src() & m_mask};
            10'h088: return {27'd0, exp_src()};
            10'h0C0: return {24'd0, m_id};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input bit w, input logic [AW-1:0] wa, input logic [31:0] wd,
                        input bit r, input logic [AW-1:0] ra,
                        input bit sv, input logic [7:0] sid, input bit ov, input string tag);
        logic [31:0] er;
        wr_en = w; wr_addr = wa; wr_data = wd;
        rd_en = r; rd_addr = ra;
        sync_valid = sv; sync_id = sid; offload_sync_valid = ov;
        er = exp_read(ra);
        @(posedge clk);
        if (sv) begin m_f3 = 1'b1; m_id = sid; end
        else if (w && wa == 10'h084 && wd[3]) m_f3 = 1'b0;
        if (ov) m_f4 = 1'b1;
        else if (w && wa == 10'h084 && wd[4]) m_f4 = 1'b0;
        if (w && wa == 10'h080) m_mask = wd[4:0];
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; sync_valid = 1'b0; offload_sync_valid = 1'b0;
        if (r) check(tag, rd_data, er);
        check("R10 irq", {31'd0, irq}, {31'd0, |(exp_src() & m_mask)});
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        step(1'b0, '0, '0, 1'b1, a, 1'b0, '0, 1'b0, tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        step(1'b1, a, d, 1'b0, '0, 1'b0, '0, 1'b0, "wr");
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        rd(10'h080, "R1 mask reset");
        rd(10'h0C0, "R1 sync id reset");
        rd(10'h088, "R1 raw reset");
        rd(10'h084, "R1 pending reset");

        wr(10'h080, 32'hFFFF_FFFF);
        rd(10'h080, "R2 mask upper bits");
        wr(10'h080, 32'h0000_0015);
        rd(10'h080, "R2 mask value");

        cmd_level = 5'd4; rd(10'h088, "R3 cmd at mark");
        cmd_level = 5'd3; rd(10'h088, "R3 cmd below mark");
        cmd_level = 5'd8;
        tx_level = 6'd4;  rd(10'h088, "R4 tx at mark");
        tx_level = 6'd3;  rd(10'h088, "R4 tx below mark");
        tx_level = 6'd8;
        rx_level = 6'd28; rd(10'h088, "R5 rx at mark");
        rx_level = 6'd29; rd(10'h088, "R5 rx above mark");
        rx_level = 6'd10;

        check("R6 sync_ready high", {31'd0, sync_ready}, 32'd1);
        step(1'b0, '0, '0, 1'b0, '0, 1'b1, 8'hA5, 1'b0, "R6 event");
        rd(10'h0C0, "R6 id latched");
        rd(10'h088, "R6 flag set");
        step(1'b1, 10'h084, 32'h8, 1'b0, '0, 1'b1, 8'h3C, 1'b0, "R7 clear with event");
        rd(10'h088, "R7 set wins");
        rd(10'h0C0, "R7 new id");
        wr(10'h084, 32'h8);
        rd(10'h088, "R7 cleared");

        step(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b1, "R8 strobe");
        rd(10'h084, "R8 pending set");
        step(1'b1, 10'h084, 32'h10, 1'b0, '0, 1'b0, '0, 1'b1, "R8 clear with strobe");
        rd(10'h088, "R8 strobe wins");
        wr(10'h084, 32'h10);
        rd(10'h088, "R8 cleared");

        wr(10'h080, 32'h1F);
        cmd_level = 5'd0; tx_level = 6'd1; rx_level = 6'd32;
        wr(10'h084, 32'h7);
        rd(10'h088, "R11 level bits survive w1c");
        rd(10'h084, "R9 pending masked");
        wr(10'h080, 32'h02);
        rd(10'h084, "R9 pending one bit");
        cmd_level = 5'd8; tx_level = 6'd8; rx_level = 6'd10;

        rd(10'h010, "R12 unmapped read");
        rd(10'h1FC, "R12 unmapped high read");
        wr(10'h088, 32'hFFFF_FFFF);
        wr(10'h0C0, 32'hFFFF_FFFF);
        wr(10'h010, 32'hFFFF_FFFF);
        rd(10'h0C0, "R12 id unchanged");
        rd(10'h088, "R12 raw unchanged");
        rd(10'h080, "R12 mask unchanged");

        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] ra, wa;
            logic [31:0] wd;
            bit w;
            cmd_level = CMD_W'($urandom_range(0, 16));
            tx_level  = TX_W'($urandom_range(0, 32));
            rx_level  = RX_W'($urandom_range(0, 32));
            case ($urandom % 6)
                0: ra = 10'h080; 1: ra = 10'h084; 2: ra = 10'h088;
                3: ra = 10'h0C0; 4: ra = 10'h010; default: ra = 10'h1FC;
            endcase
            case ($urandom % 4)
                0: wa = 10'h080; 1: wa = 10'h084; 2: wa = 10'h088; default: wa = 10'h0C0;
            endcase
            wd = $urandom;
            w  = ($urandom % 3) == 0;
            step(w, wa, wd, 1'b1, ra, ($urandom % 5) == 0, 8'($urandom),
                 ($urandom % 6) == 0, "R9 random read");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule